// File: doc/BRIEF.md
# PHY Event Interrupt and Address Filter Register Slice

This block is one slice of an Ethernet controller's host register file. It keeps two PHY-related interrupt sources, each with its own enable. The first source reports that an internally generated management frame has finished. The second reports that the PHY-present status has toggled. The slice also keeps the 64-bit logical (multicast hash) address filter as four 16-bit words.

A host reaches the slice through a simple single-cycle write strobe with an address and write data. Reads are combinational from the address. The management engine supplies a one-cycle completion pulse, and the PHY logic supplies a present level. The slice drives a level interrupt that is the OR of the enabled sources.

There are two resets. The hard reset is asynchronous and active low, and it clears the interrupt state. The soft reset and the stop input leave both the interrupt state and the filter untouched. The filter words can be reached only while the controller is stopped or suspended.

Top module: `phy_evt_filter_regs`

## Requirements
- R1: The control word sits at address 0. Bit 1 is the detect flag and bit 3 is the completion flag. Writing 1 to either bit clears that flag.
- R2: Writing 0 to a flag bit leaves that flag unchanged. Bit 0 is the detect enable and bit 2 is the completion enable. Both enables are plain read/write bits.
- R3: The hard reset sets both flags, both enables and `irq` to 0. A `soft_rst` pulse or a raised `stop` changes none of them.
- R4: The detect flag sets when `phy_present` goes 0 to 1 and when it goes 1 to 0, whatever the value of its enable. The flag reads 1 after the second rising clock edge that follows the change of the input.
- R5: A `mgmt_done` pulse sets the completion flag at that edge if the completion enable is 1. If the enable is 0, the pulse does nothing.
- R6: If a flag is set and cleared by a write-1 in the same cycle, the flag ends up set.
- R7: Bit 4 of the control word is read-only. It reads as the OR of (detect flag AND detect enable) and (completion flag AND completion enable). `irq` shows the same value one clock later. All other upper bits of the control word read 0.
- R8: Filter word i (i = 0..3) sits at address 1+i in bits 15:0 and holds filter bits 16i+15 down to 16i. A write to a filter word takes effect only while `stop` or `suspend` is 1. Any other write to a filter word is ignored.
- R9: A filter read returns the word in bits 15:0, with bits 31:16 reading 0, while `stop` or `suspend` is 1. Otherwise the read returns 0. Bits 31:16 of a filter write are discarded.
- R10: The filter words keep their contents through the hard reset, `soft_rst` and `stop`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hard reset |
| soft_rst | input | 1 | Soft reset pulse; has no effect on this slice |
| stop | input | 1 | Controller stopped; opens the filter for access |
| suspend | input | 1 | Controller suspended; opens the filter for access |
| phy_present | input | 1 | PHY-present status level |
| mgmt_done | input | 1 | One-cycle pulse when a management frame finishes |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| irq | output | 1 | Registered interrupt level |

## Verification
The detect input is driven both with a rising step and with a falling step, which shows that both edges set the flag. A step is also applied with the detect enable clear, which separates setting the flag from raising the interrupt. Completion pulses are applied with the enable clear and with it set. A pulse is also made to coincide with a write-1 clear, which exposes the priority between set and clear. The filter is written and read with the access window closed, with it opened by `stop`, and with it opened by `suspend`, using data whose upper bits are set. A hard reset and a soft reset pulse then separate the state that each reset clears from the state it keeps.

// File: rtl/pef_pkg.sv
package pef_pkg;
   localparam int CTL_DET_EN   = 0;
   localparam int CTL_DET_FLAG = 1;
   localparam int CTL_MG_EN    = 2;
   localparam int CTL_MG_FLAG  = 3;
   localparam int CTL_SUM      = 4;

   typedef struct packed {
      logic flag;
      logic en;
   } evt_state_t;
endpackage

// File: rtl/pef_event_flag.sv
module pef_event_flag
   import pef_pkg::*;
#(
   parameter bit GATE_SET = 1'b0
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       set_pulse,
   input  logic       wr_sel,
   input  logic       wr_en_bit,
   input  logic       wr_clr_bit,
   output evt_state_t st
);
   logic set_eff;

   generate
      if (GATE_SET) begin : g_gated
         assign set_eff = set_pulse & st.en;
      end else begin : g_free
         assign set_eff = set_pulse;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st <= '0;
      end else begin
         if (wr_sel) st.en <= wr_en_bit;
         if (set_eff) st.flag <= 1'b1;
         else if (wr_sel && wr_clr_bit) st.flag <= 1'b0;
      end
   end
endmodule

// File: rtl/pef_level_toggle.sv
module pef_level_toggle (
   input  logic clk,
   input  logic rst_n,
   input  logic lvl_in,
   output logic toggled
);
   logic lvl_q;
   logic lvl_hist;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lvl_q    <= 1'b0;
         lvl_hist <= 1'b0;
      end else begin
         lvl_q    <= lvl_in;
         lvl_hist <= lvl_q;
      end
   end

   assign toggled = lvl_q ^ lvl_hist;
endmodule

// File: rtl/pef_filter_bank.sv
module pef_filter_bank #(
   parameter int WORDS  = 4,
   parameter int WORD_W = 16,
   parameter int BUS_W  = 32,
   parameter int ADDR_W = 3,
   parameter int BASE   = 1
) (
   input  logic                    clk,
   input  logic                    open_win,
   input  logic                    wr,
   input  logic [ADDR_W-1:0]       addr,
   input  logic [BUS_W-1:0]        wdata,
   output logic                    hit,
   output logic [WORD_W-1:0]       rword,
   output logic [WORDS*WORD_W-1:0] flat
);
   logic [WORD_W-1:0] mem [WORDS];
   logic [WORDS-1:0]  sel;

   generate
      for (genvar i = 0; i < WORDS; i++) begin : g_word
         assign sel[i] = (addr == ADDR_W'(BASE + i));
         always_ff @(posedge clk) begin
            if (open_win && wr && sel[i]) mem[i] <= wdata[WORD_W-1:0];
         end
         assign flat[i*WORD_W +: WORD_W] = mem[i];
      end
   endgenerate

   assign hit = |sel;

   always_comb begin
      rword = '0;
      for (int k = 0; k < WORDS; k++) begin
         if (sel[k]) rword = mem[k];
      end
   end
endmodule

// File: rtl/phy_evt_filter_regs.sv
module phy_evt_filter_regs
   import pef_pkg::*;
#(
   parameter int  FILT_W    = 64,
   parameter int  WORD_W    = 16,
   parameter int  BUS_W     = 32,
   parameter int  ADDR_W    = 3,
   parameter int  CTRL_ADDR = 0,
   parameter int  FILT_BASE = 1,
   parameter bit  IRQ_REG   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              soft_rst,
   input  logic              stop,
   input  logic              suspend,
   input  logic              phy_present,
   input  logic              mgmt_done,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [BUS_W-1:0]  bus_wdata,
   output logic [BUS_W-1:0]  bus_rdata,
   output logic              irq
);
   localparam int WORDS = FILT_W / WORD_W;

   generate
      if (FILT_W % WORD_W != 0) begin : g_bad_split
         $error("filter width must be a multiple of the word width");
      end
      if (WORD_W > BUS_W || BUS_W < 5) begin : g_bad_bus
         $error("bus too narrow for register contents");
      end
      if (FILT_BASE + WORDS > (1 << ADDR_W) || CTRL_ADDR >= FILT_BASE) begin : g_bad_map
         $error("register map does not fit the address space");
      end
   endgenerate

   evt_state_t det_st, mg_st;
   logic ctrl_sel, det_set, open_win, filt_hit, sum;
   logic [WORD_W-1:0] filt_word;
   logic [FILT_W-1:0] filt_flat;
   logic unused_ok;

   assign ctrl_sel = bus_wr && (bus_addr == ADDR_W'(CTRL_ADDR));
   assign open_win = stop | suspend;

   pef_level_toggle u_tog (
      .clk(clk), .rst_n(rst_n), .lvl_in(phy_present), .toggled(det_set)
   );

   pef_event_flag #(.GATE_SET(1'b0)) u_det (
      .clk(clk), .rst_n(rst_n), .set_pulse(det_set), .wr_sel(ctrl_sel),
      .wr_en_bit(bus_wdata[CTL_DET_EN]), .wr_clr_bit(bus_wdata[CTL_DET_FLAG]),
      .st(det_st)
   );

   pef_event_flag #(.GATE_SET(1'b1)) u_mg (
      .clk(clk), .rst_n(rst_n), .set_pulse(mgmt_done), .wr_sel(ctrl_sel),
      .wr_en_bit(bus_wdata[CTL_MG_EN]), .wr_clr_bit(bus_wdata[CTL_MG_FLAG]),
      .st(mg_st)
   );

   pef_filter_bank #(
      .WORDS(WORDS), .WORD_W(WORD_W), .BUS_W(BUS_W), .ADDR_W(ADDR_W), .BASE(FILT_BASE)
   ) u_filt (
      .clk(clk), .open_win(open_win), .wr(bus_wr), .addr(bus_addr),
      .wdata(bus_wdata), .hit(filt_hit), .rword(filt_word), .flat(filt_flat)
   );

   assign sum = (det_st.flag & det_st.en) | (mg_st.flag & mg_st.en);

   generate
      if (IRQ_REG) begin : g_irq_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) irq <= 1'b0;
            else        irq <= sum;
         end
      end else begin : g_irq_comb
         assign irq = sum;
      end
   endgenerate

   always_comb begin
      bus_rdata = '0;
      if (bus_addr == ADDR_W'(CTRL_ADDR)) begin
         bus_rdata[CTL_DET_EN]   = det_st.en;
         bus_rdata[CTL_DET_FLAG] = det_st.flag;
         bus_rdata[CTL_MG_EN]    = mg_st.en;
         bus_rdata[CTL_MG_FLAG]  = mg_st.flag;
         bus_rdata[CTL_SUM]      = sum;
      end else if (filt_hit && open_win) begin
         bus_rdata[WORD_W-1:0] = filt_word;
      end
   end

   assign unused_ok = ^{soft_rst, bus_wdata};
endmodule

// File: rtl/pef_checker.sv
module pef_checker #(
   parameter int FILT_W    = 64,
   parameter int ADDR_W    = 3,
   parameter int BUS_W     = 32,
   parameter int FILT_BASE = 1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              soft_rst,
   input logic              stop,
   input logic              suspend,
   input logic              mgmt_done,
   input logic              bus_wr,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [BUS_W-1:0]  bus_wdata,
   input logic [BUS_W-1:0]  bus_rdata,
   input logic              irq,
   input logic              det_set,
   input logic              det_flag,
   input logic              det_en,
   input logic              mg_flag,
   input logic              mg_en,
   input logic [FILT_W-1:0] filt_flat
);
   logic ctrl_wr, filt_addr;
   assign ctrl_wr   = bus_wr && bus_addr == '0;
   assign filt_addr = bus_addr >= ADDR_W'(FILT_BASE) && bus_addr < ADDR_W'(FILT_BASE + FILT_W / 16);

   assert_w1c_R1: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_wr && bus_wdata[1] && !det_set |=> !det_flag);

   assert_zero_keeps_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_wr && !bus_wdata[3] && mg_flag |=> mg_flag);

   assert_soft_keep_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (soft_rst || stop) && !bus_wr |=> $stable(det_flag) || det_flag);

   assert_edge_R4: assert property (@(posedge clk) disable iff (!rst_n)
      det_set |=> det_flag);

   assert_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !mg_en && !mg_flag && !bus_wr |=> !mg_flag);

   assert_set_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
      mgmt_done && mg_en |=> mg_flag);

   assert_irq_R7: assert property (@(posedge clk) disable iff (!rst_n)
      det_flag && det_en |=> irq);

   assert_locked_R8: assert property (@(posedge clk) disable iff (!rst_n)
      bus_wr && filt_addr && !(stop || suspend) |=> $stable(filt_flat));

   assert_rd_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
      filt_addr && !(stop || suspend) |-> bus_rdata == '0);

   assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_wr |=> $stable(filt_flat));
endmodule

bind phy_evt_filter_regs pef_checker #(
   .FILT_W(FILT_W), .ADDR_W(ADDR_W), .BUS_W(BUS_W), .FILT_BASE(FILT_BASE)
) u_chk (
   .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .stop(stop), .suspend(suspend),
   .mgmt_done(mgmt_done), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
   .bus_rdata(bus_rdata), .irq(irq), .det_set(det_set), .det_flag(det_st.flag),
   .det_en(det_st.en), .mg_flag(mg_st.flag), .mg_en(mg_st.en), .filt_flat(filt_flat)
);

// File: tb/sim_phy_evt_filter_regs.sv
`timescale 1ns/1ps
module sim_phy_evt_filter_regs;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic soft_rst = 1'b0, stop = 1'b0, suspend = 1'b0;
   logic phy_present = 1'b0, mgmt_done = 1'b0, bus_wr = 1'b0;
   logic [2:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic irq;
   int total = 0, bad = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   phy_evt_filter_regs u0 (
      .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .stop(stop), .suspend(suspend),
      .phy_present(phy_present), .mgmt_done(mgmt_done), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0; bus_wdata = '0;
   endtask

   task automatic rd_chk(input string req, input logic [2:0] a, input logic [31:0] exp);
      bus_addr = a;
      #1;
      chk(req, bus_rdata, exp);
   endtask

   task automatic t_reset;
      rd_chk("R3 reset ctrl", 3'd0, 32'h0);
      chk("R3 reset irq", {31'b0, irq}, 32'h0);
   endtask

   task automatic t_detect;
      wr(3'd0, 32'h1);
      rd_chk("R2 enable rw", 3'd0, 32'h1);
      @(negedge clk); phy_present = 1'b1;
      @(negedge clk);
      rd_chk("R4 not yet", 3'd0, 32'h1);
      @(negedge clk);
      rd_chk("R4 rise sets, R7 sum", 3'd0, 32'h13);
      chk("R7 irq lags", {31'b0, irq}, 32'h0);
      @(negedge clk);
      chk("R7 irq high", {31'b0, irq}, 32'h1);
      wr(3'd0, 32'h1);
      rd_chk("R2 zero keeps flag", 3'd0, 32'h13);
      wr(3'd0, 32'h3);
      rd_chk("R1 w1c detect", 3'd0, 32'h1);
      @(negedge clk);
      chk("R7 irq drops", {31'b0, irq}, 32'h0);
      wr(3'd0, 32'h0);
      @(negedge clk); phy_present = 1'b0;
      repeat (3) @(negedge clk);
      rd_chk("R4 fall sets without enable", 3'd0, 32'h2);
      chk("R7 no irq when disabled", {31'b0, irq}, 32'h0);
      wr(3'd0, 32'h2);
      rd_chk("R1 clear again", 3'd0, 32'h0);
   endtask

   task automatic t_mgmt;
      @(negedge clk); mgmt_done = 1'b1;
      @(negedge clk); mgmt_done = 1'b0;
      rd_chk("R5 gated off", 3'd0, 32'h0);
      wr(3'd0, 32'h4);
      @(negedge clk); mgmt_done = 1'b1;
      @(negedge clk); mgmt_done = 1'b0;
      rd_chk("R5 sets when enabled", 3'd0, 32'h1C);
      wr(3'd0, 32'hC);
      rd_chk("R1 w1c completion", 3'd0, 32'h4);
      @(negedge clk);
      mgmt_done = 1'b1; bus_wr = 1'b1; bus_addr = 3'd0; bus_wdata = 32'hC;
      @(negedge clk);
      mgmt_done = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
      rd_chk("R6 set beats clear", 3'd0, 32'h1C);
   endtask

   task automatic t_keep;
      @(negedge clk); soft_rst = 1'b1; stop = 1'b1;
      @(negedge clk); soft_rst = 1'b0;
      @(negedge clk);
      rd_chk("R3 soft reset and stop keep", 3'd0, 32'h1C);
      stop = 1'b0;
   endtask

   task automatic t_filter;
      wr(3'd1, 32'h0000_1111);
      rd_chk("R9 locked read zero", 3'd1, 32'h0);
      stop = 1'b1;
      for (int i = 0; i < 4; i++) wr(3'(1 + i), 32'hFFFF_0000 | (32'hA5A0 + i));
      for (int i = 0; i < 4; i++) rd_chk("R9 readback low half", 3'(1 + i), 32'hA5A0 + i);
      stop = 1'b0;
      wr(3'd2, 32'h0000_BEEF);
      suspend = 1'b1;
      rd_chk("R8 locked write ignored", 3'd2, 32'hA5A1);
      wr(3'd3, 32'h0000_1234);
      rd_chk("R8 suspend opens", 3'd3, 32'h1234);
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk); rst_n = 1'b1;
      soft_rst = 1'b1;
      @(negedge clk); soft_rst = 1'b0;
      rd_chk("R3 hard reset clears ctrl", 3'd0, 32'h0);
      chk("R3 hard reset irq", {31'b0, irq}, 32'h0);
      rd_chk("R10 word0 kept", 3'd1, 32'hA5A0);
      rd_chk("R10 word3 kept", 3'd4, 32'hA5A3);
      suspend = 1'b0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_detect();
      t_mgmt();
      t_keep();
      t_filter();
      if (!done) begin
         done = 1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1;
         total++; bad++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule